// File: doc/BRIEF.md
# Low-Transition Multi-Chain Scan Pattern Source

This block produces stimulus for a full-scan logic test. It drives one serial input per scan chain, a scan-enable, a capture strobe and a bus of primary-input values. A single Johnson register supplies a slowly changing vector. Each chain reads a different stage of that register. During loading the register rotates by one position per clock, so every chain receives its own rotation of the vector. Each chain's bit is also inverted or not by its own bit of a seed word. From one pattern to the next, a chain's loaded vector therefore changes in one position only. This keeps switching in the scan cells low.

The seed comes from a maximal-length LFSR that also drives the primary inputs. It moves to its next value only after all 2·CHAIN_LEN Johnson vectors have been used with it. Software or a test controller supplies an initial seed and a pattern budget, then pulses start. The block runs autonomously and raises done when the budget is spent.

The scan outputs are a timed serial stream with no valid/ready handshake. The chains are written on every cycle that scan_en_o is high, and the stream cannot be stalled. The consumer must accept one bit per chain on each of those cycles.

Top module: `msic_pattern_gen`

## Requirements
- R1: During and after reset, scan_en_o, capture_o and done_o are 0, scan_in_o is 0 and pi_o is the value 1 (only bit 0 set).
- R2: A start pulse taken while idle or done loads seed_i into the seed register, or the value 1 if seed_i is zero, and clears the Johnson register to all zeros. The new seed is visible on pi_o in the next cycle.
- R3: Each pattern takes CHAIN_LEN+2 cycles: one advance cycle with scan_en_o and capture_o low, then exactly CHAIN_LEN cycles with scan_en_o high, then one cycle with capture_o high. scan_en_o and capture_o are never high together.
- R4: The Johnson register J has CHAIN_LEN bits. An advance performs J <= {J[LEN-2:0], ~J[LEN-1]}, so the first pattern after start uses J = 1. Each shift cycle rotates J left by one position, and J returns to its pre-shift value after CHAIN_LEN shifts.
- R5: On every shift cycle, scan_in_o[c] = J[c] XOR seed[c]. The first bit shifted ends at the far end of the chain.
- R6: pi_o always equals the seed register and does not change while scan_en_o is high.
- R7: After every 2·CHAIN_LEN-th capture the seed steps as a left-shifting LFSR: s <= {s[W-2:0], parity(s & TAPS)}. For the default 5-bit width, TAPS selects bits 4 and 2. The seed is never zero and runs through 2^W−1 distinct values.
- R8: The pattern stream repeats with period 2·CHAIN_LEN·(2^SEED_W−1) and contains no repeated pattern within one period. For the defaults this is 496 patterns.
- R9: Two consecutive patterns that share a seed differ in exactly one bit of every chain.
- R10: done_o rises in the cycle after the capture that brings the pattern count to the pat_limit_i value sampled at start. A limit of 0 raises done_o one cycle after start, with no pattern. done_o holds, with scan activity stopped, until the next start.
- R11: start_i is ignored while a run is in progress: the seed, limit and pattern stream are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (taken only when idle or done) |
| seed_i | input | SEED_W | Initial seed for the run |
| pat_limit_i | input | CNT_W | Number of patterns to apply |
| scan_in_o | output | NCHAIN | Serial data, one bit per scan chain |
| scan_en_o | output | 1 | High on shift cycles |
| capture_o | output | 1 | One-cycle capture strobe per pattern |
| pi_o | output | SEED_W | Primary-input values (current seed) |
| done_o | output | 1 | Pattern budget applied |

## Verification
Several seeds are used, including an all-ones seed and a zero seed. Short budgets separate the Johnson progression within one seed from the seed step. A budget of 17 or 20 crosses the point where the seed must advance, which shows whether that happens after exactly 2·CHAIN_LEN patterns. A full-period run of 497 patterns tests uniqueness, the wrap back to the first pattern and the single-bit change per chain. A zero budget and a start pulse during a run test the control corners.

// File: rtl/msic_pkg.sv
package msic_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADV,
    PH_SHIFT,
    PH_CAPT,
    PH_DONE
  } phase_t;

  // Feedback masks for a left-shifting maximal-length LFSR, bit index = tap-1.
  function automatic logic [31:0] lfsr_taps(input int w);
    case (w)
      3:       return 32'h0000_0006;
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0014;
      6:       return 32'h0000_0030;
      7:       return 32'h0000_0060;
      8:       return 32'h0000_00B8;
      9:       return 32'h0000_0110;
      10:      return 32'h0000_0240;
      11:      return 32'h0000_0500;
      12:      return 32'h0000_0829;
      13:      return 32'h0000_100D;
      14:      return 32'h0000_2015;
      15:      return 32'h0000_6000;
      16:      return 32'h0000_D008;
      default: return 32'h0000_0014;
    endcase
  endfunction

endpackage

// File: rtl/msic_seed_lfsr.sv
module msic_seed_lfsr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] seed_o
);
  localparam logic [W-1:0] TAPS = W'(msic_pkg::lfsr_taps(W));
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= ONE;
    end else if (load_i) begin
      s_q <= (seed_i == '0) ? ONE : seed_i;
    end else if (step_i) begin
      s_q <= {s_q[W-2:0], ^(s_q & TAPS)};
    end
  end

  assign seed_o = s_q;
endmodule

// File: rtl/msic_johnson_src.sv
module msic_johnson_src #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           adv_i,
  input  logic           rot_i,
  output logic [LEN-1:0] vec_o
);
  logic [LEN-1:0] v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (clear_i) begin
      v_q <= '0;
    end else if (adv_i) begin
      v_q <= {v_q[LEN-2:0], ~v_q[LEN-1]};
    end else if (rot_i) begin
      v_q <= {v_q[LEN-2:0], v_q[LEN-1]};
    end
  end

  assign vec_o = v_q;
endmodule

// File: rtl/msic_xor_net.sv
module msic_xor_net #(
  parameter int NCHAIN = 4
) (
  input  logic              en_i,
  input  logic [NCHAIN-1:0] tap_i,
  input  logic [NCHAIN-1:0] seed_i,
  output logic [NCHAIN-1:0] scan_o
);
  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    assign scan_o[c] = en_i & (tap_i[c] ^ seed_i[c]);
  end
endmodule

// File: rtl/msic_ctrl.sv
module msic_ctrl #(
  parameter int LEN   = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             rot_o,
  output logic             capt_o,
  output logic             step_o,
  output logic             done_o
);
  import msic_pkg::*;

  localparam int SH_W  = (LEN > 1) ? $clog2(LEN) : 1;
  localparam int BLK_W = $clog2(2 * LEN);
  localparam logic [SH_W-1:0]  SH_LAST  = SH_W'(LEN - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(2 * LEN - 1);

  phase_t           ph_q;
  logic [SH_W-1:0]  sh_q;
  logic [BLK_W-1:0] blk_q;
  logic [CNT_W-1:0] pat_q;
  logic [CNT_W-1:0] lim_q;
  logic             accept;
  logic             last_pat;

  assign accept   = start_i && (ph_q == PH_IDLE || ph_q == PH_DONE);
  assign last_pat = (pat_q + CNT_W'(1)) == lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      sh_q  <= '0;
      blk_q <= '0;
      pat_q <= '0;
      lim_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE, PH_DONE: begin
          if (accept) begin
            lim_q <= limit_i;
            pat_q <= '0;
            blk_q <= '0;
            ph_q  <= (limit_i == '0) ? PH_DONE : PH_ADV;
          end
        end
        PH_ADV: begin
          sh_q <= '0;
          ph_q <= PH_SHIFT;
        end
        PH_SHIFT: begin
          sh_q <= sh_q + SH_W'(1);
          if (sh_q == SH_LAST) ph_q <= PH_CAPT;
        end
        PH_CAPT: begin
          pat_q <= pat_q + CNT_W'(1);
          blk_q <= (blk_q == BLK_LAST) ? '0 : blk_q + BLK_W'(1);
          ph_q  <= last_pat ? PH_DONE : PH_ADV;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign load_o = accept;
  assign adv_o  = (ph_q == PH_ADV);
  assign rot_o  = (ph_q == PH_SHIFT);
  assign capt_o = (ph_q == PH_CAPT);
  assign step_o = (ph_q == PH_CAPT) && (blk_q == BLK_LAST);
  assign done_o = (ph_q == PH_DONE);
endmodule

// File: rtl/msic_pattern_gen.sv
module msic_pattern_gen #(
  parameter int NCHAIN    = 4,
  parameter int CHAIN_LEN = 8,
  parameter int SEED_W    = 5,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic [CNT_W-1:0]  pat_limit_i,
  output logic [NCHAIN-1:0] scan_in_o,
  output logic              scan_en_o,
  output logic              capture_o,
  output logic [SEED_W-1:0] pi_o,
  output logic              done_o
);
  logic                 load, adv, rot, capt, step;
  logic [SEED_W-1:0]    seed;
  logic [CHAIN_LEN-1:0] jvec;

  msic_ctrl #(.LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .limit_i(pat_limit_i),
    .load_o(load), .adv_o(adv), .rot_o(rot), .capt_o(capt),
    .step_o(step), .done_o(done_o)
  );

  msic_seed_lfsr #(.W(SEED_W)) u_seed (
    .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed_i),
    .step_i(step), .seed_o(seed)
  );

  msic_johnson_src #(.LEN(CHAIN_LEN)) u_john (
    .clk(clk), .rst_n(rst_n), .clear_i(load), .adv_i(adv),
    .rot_i(rot), .vec_o(jvec)
  );

  msic_xor_net #(.NCHAIN(NCHAIN)) u_xor (
    .en_i(rot), .tap_i(jvec[NCHAIN-1:0]), .seed_i(seed[NCHAIN-1:0]),
    .scan_o(scan_in_o)
  );

  assign scan_en_o = rot;
  assign capture_o = capt;
  assign pi_o      = seed;
endmodule

// File: rtl/msic_pattern_gen_chk.sv
module msic_pattern_gen_chk #(
  parameter int CHAIN_LEN = 8,
  parameter int SEED_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_en_o,
  input logic              capture_o,
  input logic [SEED_W-1:0] pi_o,
  input logic              done_o
);
  localparam int RUN_W = $clog2(CHAIN_LEN + 1) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= scan_en_o ? run_q + RUN_W'(1) : '0;
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en_o && capture_o));

  assert_shift_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en_o) |-> (run_q == RUN_W'(CHAIN_LEN) && capture_o));

  assert_capture_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> !capture_o);

  assert_pi_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_o && $past(scan_en_o)) |-> $stable(pi_o));

  assert_seed_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pi_o != '0);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!scan_en_o && !capture_o));
endmodule

bind msic_pattern_gen msic_pattern_gen_chk #(
  .CHAIN_LEN(CHAIN_LEN), .SEED_W(SEED_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .scan_en_o(scan_en_o), .capture_o(capture_o),
  .pi_o(pi_o), .done_o(done_o)
);

// File: tb/test_msic_pattern_gen.sv
`timescale 1ns/1ps
module test_msic_pattern_gen;
  localparam int NC = 4, LN = 8, SW = 5, CW = 16;
  localparam int MAXP = 600;
  localparam int BLK = 2 * LN;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [SW-1:0] seed_in = '0;
  logic [CW-1:0] limit = '0;
  logic [NC-1:0] scan_in;
  logic scan_en, capture, done;
  logic [SW-1:0] pi;

  always #2.5 clk = ~clk;

  msic_pattern_gen #(.NCHAIN(NC), .CHAIN_LEN(LN), .SEED_W(SW), .CNT_W(CW)) i_msic_pattern_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .seed_i(seed_in),
    .pat_limit_i(limit), .scan_in_o(scan_in), .scan_en_o(scan_en),
    .capture_o(capture), .pi_o(pi), .done_o(done)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // capture monitor
  logic [LN-1:0] sh [NC];
  logic [LN-1:0] cap_ch [MAXP][NC];
  logic [SW-1:0] cap_pi [MAXP];
  int idx = 0;

  always @(negedge clk) begin
    if (scan_en)
      for (int c = 0; c < NC; c++) sh[c] = {sh[c][LN-2:0], scan_in[c]};
    if (capture && idx < MAXP) begin
      for (int c = 0; c < NC; c++) cap_ch[idx][c] = sh[c];
      cap_pi[idx] = pi;
      idx++;
    end
  end

  // reference model from the requirements
  function automatic logic [LN-1:0] jvec_at(input int n);
    logic [LN-1:0] v = '0;
    for (int k = 0; k < n; k++) v = {v[LN-2:0], ~v[LN-1]};
    return v;
  endfunction

  function automatic logic [SW-1:0] seed_at(input logic [SW-1:0] s0, input int n);
    logic [SW-1:0] s = (s0 == '0) ? SW'(1) : s0;
    for (int k = 0; k < n; k++) s = {s[SW-2:0], s[4] ^ s[2]};
    return s;
  endfunction

  function automatic logic [LN-1:0] chain_exp(input logic [LN-1:0] jv, input logic sb, input int c);
    logic [LN-1:0] r;
    for (int k = 0; k < LN; k++) r[LN-1-k] = jv[(c - k + LN) % LN] ^ sb;
    return r;
  endfunction

  task automatic wait_done(input int maxc, input string req);
    int n = 0;
    while (!done && n < maxc) begin @(negedge clk); n++; end
    check({63'd0, done}, 64'd1, {req, " done within budget"});
  endtask

  task automatic run(input logic [SW-1:0] s, input int lim, input int maxc);
    @(negedge clk);
    idx = 0;
    seed_in = s; limit = CW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(maxc, "R10");
  endtask

  task automatic compare_run(input logic [SW-1:0] s, input int lim, input string tag);
    check(64'(idx), 64'(lim), {tag, " R10 pattern count"});
    for (int p = 0; p < idx && p < lim; p++) begin
      logic [SW-1:0] es = seed_at(s, p / BLK);
      logic [LN-1:0] jv = jvec_at((p % BLK) + 1);
      logic ok = (cap_pi[p] == es);
      for (int c = 0; c < NC; c++) ok &= (cap_ch[p][c] == chain_exp(jv, es[c], c));
      check({63'd0, ok}, 64'd1, $sformatf("%s R4 R5 R7 pattern %0d pi=%0h exp_pi=%0h", tag, p, cap_pi[p], es));
    end
  endtask

  typedef struct packed { logic [SW-1:0] seed; logic [CW-1:0] lim; } vec_t;
  localparam vec_t VECS [5] = '{
    '{5'b01101, 16'd3}, '{5'b00001, 16'd2}, '{5'b11111, 16'd20},
    '{5'b00000, 16'd2}, '{5'b10010, 16'd17}
  };

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({60'd0, scan_en, capture, done, |scan_in}, 64'd0, "R1 idle outputs in reset");
    check(64'(pi), 64'd1, "R1 seed reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(64'(pi), 64'd1, "R1 seed after reset");

    // table walk
    for (int v = 0; v < 5; v++) begin
      run(VECS[v].seed, int'(VECS[v].lim), 2000);
      compare_run(VECS[v].seed, int'(VECS[v].lim), $sformatf("vec%0d", v));
    end

    // R2: zero seed replaced by 1, visible the cycle after start
    @(negedge clk);
    seed_in = 5'b00000; limit = 16'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(64'(pi), 64'd1, "R2 zero seed loads as 1");
    wait_done(100, "R2");
    @(negedge clk);
    seed_in = 5'b10110; limit = 16'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(64'(pi), 64'h16, "R2 seed loaded");
    // R3 phase timing: now in advance cycle
    check({62'd0, scan_en, capture}, 64'd0, "R3 advance cycle quiet");
    for (int k = 0; k < LN; k++) begin
      @(negedge clk);
      check({62'd0, scan_en, capture}, 64'd2, $sformatf("R3 shift cycle %0d", k));
    end
    @(negedge clk);
    check({62'd0, scan_en, capture}, 64'd1, "R3 capture cycle");
    @(negedge clk);
    check(64'(done), 64'd1, "R10 done after last capture");
    repeat (5) @(negedge clk);
    check({61'd0, done, scan_en, capture}, 64'd4, "R10 done held, activity stopped");

    // R10 zero limit
    @(negedge clk);
    idx = 0; seed_in = 5'b00111; limit = 16'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({63'd0, done}, 64'd1, "R10 zero limit done at once");
    repeat (4) @(negedge clk);
    check(64'(idx), 64'd0, "R10 zero limit gives no pattern");

    // R11 start ignored mid-run
    @(negedge clk);
    idx = 0; seed_in = 5'b01101; limit = 16'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    seed_in = 5'b11111; limit = 16'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    seed_in = 5'b00000;
    wait_done(200, "R11");
    compare_run(5'b01101, 3, "R11 mid-run start");

    // full period: R7 R8 R9
    run(5'b01101, BLK * 31 + 1, 20000);
    compare_run(5'b01101, BLK * 31 + 1, "period");
    begin
      int dup = 0, bad1 = 0, zs = 0, dseed = 0;
      for (int a = 0; a < BLK * 31; a++) begin
        if (cap_pi[a] == '0) zs++;
        for (int b = a + 1; b < BLK * 31; b++) begin
          logic same = (cap_pi[a] == cap_pi[b]);
          for (int c = 0; c < NC; c++) same &= (cap_ch[a][c] == cap_ch[b][c]);
          if (same) dup++;
        end
        if ((a % BLK) != BLK - 1)
          for (int c = 0; c < NC; c++)
            if ($countones(cap_ch[a][c] ^ cap_ch[a+1][c]) != 1) bad1++;
      end
      for (int x = 0; x < 31; x++)
        for (int y = x + 1; y < 31; y++)
          if (cap_pi[x*BLK] == cap_pi[y*BLK]) dseed++;
      check(64'(dup), 64'd0, "R8 no repeated pattern in period");
      check(64'(bad1), 64'd0, "R9 one bit change per chain");
      check(64'(zs), 64'd0, "R7 seed never zero");
      check(64'(dseed), 64'd0, "R7 31 distinct seeds");
      begin
        logic wrap = (cap_pi[BLK*31] == cap_pi[0]);
        for (int c = 0; c < NC; c++) wrap &= (cap_ch[BLK*31][c] == cap_ch[0][c]);
        check({63'd0, wrap}, 64'd1, "R8 sequence wraps after 496");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule